// File: doc/BRIEF.md
# Block-Transfer DMA Engine (Device Buffer to Memory)

This engine copies a block of words from a device-side buffer into system memory without the host processor touching each word. The host sets it up with three I/O writes. One write sets the memory base address. One sets the word count, written as N-1 for a block of N words. A third write starts the transfer. The device buffer is a small read-only table inside the block. Its contents are computed from two parameters.

After the start write, the engine raises its bus request and waits for a grant. It then drives a memory-write command, an address and a data word onto the system bus. It holds them until the memory acknowledges, and steps three counters together on each acknowledge. These counters are the buffer index (up from 0), the memory address (up from the base) and the remaining count (down to zero). The last write is the one issued while the remaining count is already zero. The engine then lets go of the bus, waits one quiet cycle, and raises an interrupt. The interrupt stays high until the host acknowledges it.

Top module: `dma_blk_engine`

## Requirements
- R1: An I/O write to port 1 while the engine is idle sets the base address. The first word of the next transfer goes to that address.
- R2: An I/O write to port 2 while idle sets the count to N-1. The next transfer then performs exactly N memory writes.
- R3: An I/O write to port 4 while idle starts a transfer, whatever value is on the data input. Bus request is high from the next cycle.
- R4: Bus enable is never high without bus request. Bus enable rises only after a cycle in which grant was high. While waiting for the grant, the request stays high and the bus outputs stay at zero.
- R5: While bus enable is high, command is 2'b10 (memory write; 2'b00 otherwise). Word k (k = 0..N-1) is written to address (base + k) mod 2^ADDR_W. Its data is buffer entry k, where entry i holds (29*i + 90) mod 2^DATA_W with default parameters.
- R6: Without an acknowledge, address and data hold steady. Each acknowledge moves to the next word.
- R7: After the acknowledge of the last word, request and enable drop together. The interrupt stays low for that one cycle.
- R8: The interrupt then rises and stays high until an interrupt acknowledge is seen. It is low from the following cycle.
- R9: Writes to ports 1, 2 and 4 while a transfer is in progress have no effect on the running transfer.
- R10: Synchronous active-low reset returns the engine to idle, with request, enable and interrupt low on the next cycle, even in mid-transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_io_wr | input | 1 | Host I/O write strobe, one cycle per write |
| host_port | input | PORT_W | Port number of the host write (1 base, 2 count, 4 start) |
| host_data | input | DATA_W | Host write data |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_en | output | 1 | Bus driver enable; command, address and data are valid |
| bus_cmd | output | 2 | Bus command: 2'b10 memory write, 2'b00 none |
| bus_addr | output | ADDR_W | Memory write address |
| bus_data | output | DATA_W | Memory write data |
| bus_ack | input | 1 | Memory acknowledge of the current write |
| irq | output | 1 | Completion interrupt |
| irq_ack | input | 1 | Host interrupt acknowledge |

## Verification
Every cycle, the assertions check that the request and enable handshake is well formed. They also check that address and data stay stable while a write waits for its acknowledge, that the address steps by one per acknowledged word, that a quiet cycle separates bus release from the interrupt, and that the interrupt is held until acknowledged. Some properties can only be shown by the bench scenarios. These are the exact number of writes for each programmed count, the data values taken from the buffer, wrap-around of the address, immunity to host writes in mid-transfer, and recovery from a reset during a transfer. The bench sweeps every count from 1 to 16, with different base addresses, grant delays and acknowledge delays.

// File: rtl/dma_blk_pkg.sv
// Package: shared state encoding, bus command codes and host port numbers
// for the block-transfer DMA engine. Assumes a 2-bit bus command field.
package dma_blk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_XFER = 3'd2,
        ST_DONE = 3'd3,
        ST_IRQ  = 3'd4
    } dma_state_e;

    localparam int          CMD_W     = 2;
    localparam logic [1:0]  CMD_NONE  = 2'b00;
    localparam logic [1:0]  CMD_MEMWR = 2'b10;

    localparam int PORT_NUM_BASE  = 1;
    localparam int PORT_NUM_COUNT = 2;
    localparam int PORT_NUM_GO    = 4;

endpackage

// File: rtl/dma_port_decode.sv
// Module: turns a host I/O write into one-cycle pulses for base load,
// count load and start. Assumes host_io_wr is a single-cycle strobe.
module dma_port_decode
    import dma_blk_pkg::*;
#(
    parameter int PORT_W = 3
) (
    input  logic              host_io_wr,
    input  logic [PORT_W-1:0] host_port,
    output logic              ld_base,
    output logic              ld_count,
    output logic              go
);

    // Compare the port number against each fixed port.
    always_comb begin
        ld_base  = host_io_wr && (host_port == PORT_W'(PORT_NUM_BASE));
        ld_count = host_io_wr && (host_port == PORT_W'(PORT_NUM_COUNT));
        go       = host_io_wr && (host_port == PORT_W'(PORT_NUM_GO));
    end

endmodule

// File: rtl/dma_step_counters.sv
// Module: the three lockstep counters (buffer index up from 0, memory
// address up from base, remaining count down to zero). Assumes
// DATA_W >= ADDR_W and DATA_W >= IDX_W. Loads are taken only when
// cfg_open is high.
module dma_step_counters #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_open,
    input  logic              ld_base,
    input  logic              ld_count,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              clr_idx,
    input  logic              step,
    output logic [IDX_W-1:0]  buf_idx,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              last_word
);

    logic [IDX_W-1:0] remain;

    // Memory address: load the base when idle, then step up once per word.
    always_ff @(posedge clk) begin
        if (!rst_n)                   mem_addr <= '0;
        else if (cfg_open && ld_base) mem_addr <= cfg_data[ADDR_W-1:0];
        else if (step)                mem_addr <= mem_addr + ADDR_W'(1);
    end

    // Remaining count: load N-1 when idle, then step down once per word.
    always_ff @(posedge clk) begin
        if (!rst_n)                    remain <= '0;
        else if (cfg_open && ld_count) remain <= cfg_data[IDX_W-1:0];
        else if (step)                 remain <= remain - IDX_W'(1);
    end

    // Buffer index: clear at start, then step up once per word.
    always_ff @(posedge clk) begin
        if (!rst_n)       buf_idx <= '0;
        else if (clr_idx) buf_idx <= '0;
        else if (step)    buf_idx <= buf_idx + IDX_W'(1);
    end

    // Zero flag: the current word is the last one.
    always_comb last_word = (remain == '0);

endmodule

// File: rtl/dma_buf_rom.sv
// Module: device-side buffer modelled as a computed read-only table.
// Entry i = (i*MUL + ADD) truncated to DATA_W. Assumes DEPTH = 2**IDX_W.
module dma_buf_rom #(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8,
    parameter int MUL    = 29,
    parameter int ADD    = 90
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] tbl [DEPTH];

    // One constant entry per buffer slot.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        assign tbl[gi] = DATA_W'(gi * MUL + ADD);
    end

    // Asynchronous read of the addressed entry.
    always_comb rdata = tbl[idx];

endmodule

// File: rtl/dma_bus_seq.sv
// Module: control sequencer. Idle -> request -> transfer (one word per
// acknowledge) -> one quiet cycle -> interrupt -> idle. Assumes the grant
// stays high for the whole transfer once it is given.
module dma_bus_seq
    import dma_blk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic bus_gnt,
    input  logic bus_ack,
    input  logic irq_ack,
    input  logic last_word,
    output logic idle,
    output logic clr_idx,
    output logic step,
    output logic bus_req,
    output logic bus_en,
    output logic irq
);

    dma_state_e st, st_nx;

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next-state logic.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (go)                    st_nx = ST_REQ;
            ST_REQ:  if (bus_gnt)               st_nx = ST_XFER;
            ST_XFER: if (bus_ack && last_word)  st_nx = ST_DONE;
            ST_DONE:                            st_nx = ST_IRQ;
            ST_IRQ:  if (irq_ack)               st_nx = ST_IDLE;
            default:                            st_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        idle    = (st == ST_IDLE);
        clr_idx = idle && go;
        step    = (st == ST_XFER) && bus_ack;
        bus_req = (st == ST_REQ) || (st == ST_XFER);
        bus_en  = (st == ST_XFER);
        irq     = (st == ST_IRQ);
    end

endmodule

// File: rtl/dma_blk_engine.sv
// Module: top of the block-transfer DMA engine. Connects the port decoder,
// the lockstep counters, the buffer table and the sequencer, and drives
// the bus outputs (zero while not enabled). Assumes DATA_W >= ADDR_W.
module dma_blk_engine
    import dma_blk_pkg::*;
#(
    parameter int PORT_W    = 3,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 16,
    parameter int ROM_MUL   = 29,
    parameter int ROM_ADD   = 90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_io_wr,
    input  logic [PORT_W-1:0] host_port,
    input  logic [DATA_W-1:0] host_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_en,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_ack,
    output logic              irq,
    input  logic              irq_ack
);

    localparam int IDX_W = $clog2(BUF_DEPTH);

    logic              ld_base, ld_count, go;
    logic              idle, clr_idx, step, last_word;
    logic [IDX_W-1:0]  buf_idx;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] rom_data;

    dma_port_decode #(.PORT_W(PORT_W)) u_dec (
        .host_io_wr (host_io_wr),
        .host_port  (host_port),
        .ld_base    (ld_base),
        .ld_count   (ld_count),
        .go         (go)
    );

    dma_step_counters #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_open  (idle),
        .ld_base   (ld_base),
        .ld_count  (ld_count),
        .cfg_data  (host_data),
        .clr_idx   (clr_idx),
        .step      (step),
        .buf_idx   (buf_idx),
        .mem_addr  (mem_addr),
        .last_word (last_word)
    );

    dma_buf_rom #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W),
                  .MUL(ROM_MUL), .ADD(ROM_ADD)) u_rom (
        .idx   (buf_idx),
        .rdata (rom_data)
    );

    dma_bus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .bus_gnt   (bus_gnt),
        .bus_ack   (bus_ack),
        .irq_ack   (irq_ack),
        .last_word (last_word),
        .idle      (idle),
        .clr_idx   (clr_idx),
        .step      (step),
        .bus_req   (bus_req),
        .bus_en    (bus_en),
        .irq       (irq)
    );

    // Bus drivers: valid only while enabled, zero otherwise.
    always_comb begin
        bus_cmd  = bus_en ? CMD_MEMWR : CMD_NONE;
        bus_addr = bus_en ? mem_addr  : '0;
        bus_data = bus_en ? rom_data  : '0;
    end

endmodule

// File: rtl/dma_blk_engine_chk.sv
// Module: protocol checker for dma_blk_engine, attached with bind below.
// Assumes the reset input is driven low from time zero.
module dma_blk_engine_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_ack,
    input logic              irq,
    input logic              irq_ack
);

    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !bus_en && !irq));

    a_r4_en_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> bus_req);

    a_r4_en_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_en) |-> $past(bus_gnt));

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_en) |=> bus_req);

    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_ack) |=> (bus_en && $stable(bus_addr) && $stable(bus_data)));

    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_ack) |=> (!bus_en || (bus_addr == $past(bus_addr) + ADDR_W'(1))));

    a_r7_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> (!irq && !bus_en));

    a_r7_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!bus_req && !bus_en));

    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    a_r8_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack) |=> !irq);

endmodule

bind dma_blk_engine dma_blk_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .bus_en   (bus_en),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .bus_ack  (bus_ack),
    .irq      (irq),
    .irq_ack  (irq_ack)
);

// File: tb/dma_blk_engine_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every count 1..16 with varied bases, grant and ack delays,
// host pokes mid-transfer and a mid-transfer reset. Drives and samples on
// the falling edge.
module dma_blk_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_io_wr = 1'b0;
    logic [2:0] host_port = '0;
    logic [7:0] host_data = '0;
    logic       bus_req, bus_en, irq;
    logic       bus_gnt = 1'b0, bus_ack = 1'b0, irq_ack = 1'b0;
    logic [1:0] bus_cmd;
    logic [7:0] bus_addr, bus_data;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    dma_blk_engine u_dut (
        .clk(clk), .rst_n(rst_n), .host_io_wr(host_io_wr), .host_port(host_port),
        .host_data(host_data), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_en(bus_en),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_data(bus_data), .bus_ack(bus_ack),
        .irq(irq), .irq_ack(irq_ack)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=<50000 cycles", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic logic [7:0] rom_val(input int k);
        return 8'((k * 29 + 90) & 255);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] port, input logic [7:0] data);
        host_io_wr = 1'b1; host_port = port; host_data = data;
        @(negedge clk);
        host_io_wr = 1'b0; host_data = 8'h00;
    endtask

    task automatic run_xfer(input logic [7:0] base, input int n, input int gdly,
                            input int adly, input bit poke);
        host_write(3'd1, base);                 // R1
        host_write(3'd2, 8'(n - 1));            // R2
        host_write(3'd4, base ^ 8'hA5);         // R3: data ignored
        check("R3 request after start", 32'(bus_req), 1);
        check("R4 no enable before grant", 32'(bus_en), 0);
        for (int i = 0; i < gdly; i++) begin
            @(negedge clk);
            check("R4 request held waiting", 32'(bus_req), 1);
            check("R4 bus idle waiting", {bus_en, bus_cmd, bus_addr}, 0);
        end
        bus_gnt = 1'b1;
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            check("R5 enable during word", 32'(bus_en), 1);
            check("R5 write command", 32'(bus_cmd), 32'h2);
            check("R1 R5 word address", 32'(bus_addr), 32'(8'(base + 8'(k))));
            check("R5 word data", 32'(bus_data), 32'(rom_val(k)));
            for (int d = 0; d < adly; d++) begin
                @(negedge clk);
                check("R6 address stable without ack", 32'(bus_addr), 32'(8'(base + 8'(k))));
                check("R6 data stable without ack", 32'(bus_data), 32'(rom_val(k)));
            end
            if (poke && k == 0) begin
                host_write(3'd1, ~base);
                host_write(3'd2, 8'h00);
                host_write(3'd4, 8'h00);
                check("R9 address unchanged by busy writes", 32'(bus_addr), 32'(base));
                check("R9 data unchanged by busy writes", 32'(bus_data), 32'(rom_val(0)));
            end
            bus_ack = 1'b1;
            @(negedge clk);
            bus_ack = 1'b0;
        end
        check("R2 R7 released after last word", {bus_req, bus_en, irq}, 0);
        bus_gnt = 1'b0;
        @(negedge clk);
        check("R8 interrupt raised", 32'(irq), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 interrupt held", 32'(irq), 1);
        end
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R8 interrupt cleared", {irq, bus_req}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset request", 32'(bus_req), 0);
        check("R10 reset enable and irq", {bus_en, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 1; n <= 16; n++)
            run_xfer(8'(8'hF0 + 8'(n * 3)), n, n % 3, n % 2, (n % 4) == 1);
        run_xfer(8'h00, 16, 0, 0, 1'b0);
        run_xfer(8'h7F, 3, 4, 2, 1'b1);

        // R10: reset in mid-transfer returns to idle.
        host_write(3'd1, 8'h40);
        host_write(3'd2, 8'd7);
        host_write(3'd4, 8'h00);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        check("R6 second word address", 32'(bus_addr), 32'h41);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid-transfer reset", {bus_req, bus_en, irq}, 0);
        rst_n = 1'b1;
        bus_gnt = 1'b0;
        @(negedge clk);
        check("R10 stays idle after reset", {bus_req, bus_en, irq}, 0);

        // After reset, a fresh block still runs correctly.
        run_xfer(8'h10, 2, 1, 1, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule